// File: doc/BRIEF.md
# Charge-Transfer Pulse Generator

This block sets the timing of charge-transfer cycles in a capacitive touch acquisition engine. It divides the system clock by a power of two to make a pulse-generator tick. It then drives a transfer-phase output through a high phase and a low phase, and each phase lasts a programmed number of those ticks. At the last system clock of each full high-then-low cycle it pulses a one-cycle strobe, which the acquisition counters use to count transfers.

An optional spread-spectrum mode lengthens the high phase of every cycle by an extra number of spread ticks. That extra amount rises by one per cycle from zero up to a programmed deviation and then falls back by one per cycle, as a triangle. A spread tick is one or two system clocks. Two divider and low-phase combinations are illegal. Either one raises an error flag, and the generator will not start while that flag's condition holds.

All configuration inputs are plain levels that the block samples each cycle. `run` is a level control. There is no streaming data path, so no port uses a valid/ready handshake.

Top module: `xfer_pulse_gen`

## Requirements
- R1: With spread spectrum off, `xfer_phase` stays high for (cfg_high_m1+1)*D consecutive system clocks in each cycle, where D = 2^cfg_pg_div_log2.
- R2: After the high phase, `xfer_phase` stays low for (cfg_low_m1+1)*D clocks. `cycle_done` is high in the last of these low clocks only, once per cycle, and never while `xfer_phase` is high.
- R3: The 3-bit field cfg_pg_div_log2 selects D from the set 1, 2, 4, 8, 16, 32, 64, 128, and both phase lengths scale with it.
- R4: `cfg_err` is high one clock after the configuration becomes illegal and low one clock after it becomes legal. The illegal cases are cfg_pg_div_log2=0 with cfg_low_m1=1, and cfg_pg_div_log2=1 with cfg_low_m1=0.
- R5: While the configuration is illegal, a generator that is stopped stays stopped: `xfer_phase` and `cycle_done` remain low even with `run` high. Once the configuration is legal, it starts normally.
- R6: With cfg_ss_en=1, the high phase of cycle k (counting from 0 at each start) is longer by S(k)*P clocks. S(k) is the triangle 0,1,...,dev,dev-1,...,1,0,1,... where dev is cfg_ss_dev, and S is always 0 when dev=0.
- R7: P is 1 when cfg_ss_div2=0 and 2 when cfg_ss_div2=1.
- R8: If `run` is low at the clock edge that ends a cycle, the generator stops. If `run` drops partway through a cycle, that cycle still runs to full length before the generator stops. Once stopped, `xfer_phase` and `cycle_done` stay low.
- R9: After reset, with a legal configuration and `run` low, `xfer_phase`, `cycle_done` and `cfg_err` are all low.
- R10: When the generator is stopped and `run` is sampled high at a clock edge with a legal configuration, `xfer_phase` is high in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Level request to generate cycles |
| cfg_high_m1 | input | LEN_W | High-phase length in ticks, minus one |
| cfg_low_m1 | input | LEN_W | Low-phase length in ticks, minus one |
| cfg_pg_div_log2 | input | PSC_W | log2 of the pulse-generator divider |
| cfg_ss_en | input | 1 | Spread-spectrum enable |
| cfg_ss_dev | input | DEV_W | Spread-spectrum deviation, the peak of the triangle |
| cfg_ss_div2 | input | 1 | Spread tick is two system clocks when set |
| xfer_phase | output | 1 | High during the high phase, including any stretch |
| cycle_done | output | 1 | One-clock strobe in the last clock of each cycle |
| cfg_err | output | 1 | Registered illegal-configuration flag |

## Verification
A stuck or miscounted phase counter shows at the ports within one cycle period, as a high or low run of the wrong length or as a strobe at the wrong place. A fault in the prescaler restart shifts the length by up to D-1 clocks in the first affected phase. A sweep register that steps wrongly is invisible in cycle 0 and shows in the high length of cycle 1 or at the first turning point of the triangle, so the spread runs cover two full triangle periods. A fault in the error gating shows as a transfer pulse in the first clock after `run` is raised.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HIGH    = 2'd1,
    ST_STRETCH = 2'd2,
    ST_LOW     = 2'd3
  } xpg_state_e;
endpackage

// File: rtl/xpg_prescaler.sv
// Power-of-two tick divider with synchronous restart.
module xpg_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PSC_W-1:0] div_log2,
  output logic             tick
);
  localparam int CNT_W = (2 ** PSC_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   div_val;
  logic [CNT_W-1:0] limit;

  assign div_val = (CNT_W + 1)'(1) << div_log2;
  assign limit   = CNT_W'(div_val - (CNT_W + 1)'(1));
  assign tick    = (cnt == limit) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (cnt >= limit)  cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  // R3: with a divider above one, ticks are never back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div_log2 == '0));
endmodule

// File: rtl/xpg_sweep.sv
// Triangular stretch amount, stepped once per completed cycle.
module xpg_sweep #(
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clear,
  input  logic             advance,
  input  logic [DEV_W-1:0] dev,
  output logic [DEV_W-1:0] amt
);
  logic rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amt    <= '0;
      rising <= 1'b1;
    end else if (clear || !en) begin
      amt    <= '0;
      rising <= 1'b1;
    end else if (advance) begin
      if (rising) begin
        if (amt < dev) amt <= amt + DEV_W'(1);
        else begin
          rising <= 1'b0;
          amt    <= (amt != '0) ? amt - DEV_W'(1) : '0;
        end
      end else begin
        if (amt != '0) amt <= amt - DEV_W'(1);
        else begin
          rising <= 1'b1;
          amt    <= (dev != '0) ? DEV_W'(1) : '0;
        end
      end
    end
  end

  // R6: the stretch amount moves by at most one step between cycles
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(clear)) |->
      (amt == $past(amt) || amt == $past(amt) + DEV_W'(1) || amt == $past(amt) - DEV_W'(1)));
endmodule

// File: rtl/xpg_seq.sv
// Phase sequencer: high, optional stretch, low.
module xpg_seq
  import xpg_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             illegal,
  input  logic [LEN_W-1:0] high_m1,
  input  logic [LEN_W-1:0] low_m1,
  input  logic             pg_tick,
  input  logic             ss_tick,
  input  logic [DEV_W-1:0] stretch_amt,
  output logic             pg_restart,
  output logic             ss_restart,
  output logic             idle,
  output logic             xfer_phase,
  output logic             cycle_done
);
  xpg_state_e       state;
  logic [LEN_W-1:0] ph_cnt;
  logic [DEV_W-1:0] st_cnt;
  logic             go;

  assign go         = run && !illegal;
  assign idle       = (state == ST_IDLE);
  assign pg_restart = (state == ST_IDLE) || (state == ST_STRETCH);
  assign ss_restart = (state != ST_STRETCH);
  assign xfer_phase = (state == ST_HIGH) || (state == ST_STRETCH);
  assign cycle_done = (state == ST_LOW) && pg_tick && (ph_cnt == low_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ph_cnt <= '0;
      st_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          ph_cnt <= '0;
          st_cnt <= '0;
          if (go) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (pg_tick) begin
            if (ph_cnt == high_m1) begin
              ph_cnt <= '0;
              state  <= (stretch_amt != '0) ? ST_STRETCH : ST_LOW;
            end else begin
              ph_cnt <= ph_cnt + LEN_W'(1);
            end
          end
        end
        ST_STRETCH: begin
          if (ss_tick) begin
            if (({1'b0, st_cnt} + (DEV_W + 1)'(1)) >= {1'b0, stretch_amt}) begin
              st_cnt <= '0;
              state  <= ST_LOW;
            end else begin
              st_cnt <= st_cnt + DEV_W'(1);
            end
          end
        end
        ST_LOW: begin
          if (pg_tick) begin
            if (ph_cnt == low_m1) begin
              ph_cnt <= '0;
              state  <= go ? ST_HIGH : ST_IDLE;
            end else begin
              ph_cnt <= ph_cnt + LEN_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: an illegal configuration keeps a stopped generator stopped
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && illegal) |=> (state == ST_IDLE));
endmodule

// File: rtl/xfer_pulse_gen.sv
module xfer_pulse_gen #(
  parameter int LEN_W = 4,
  parameter int PSC_W = 3,
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] cfg_high_m1,
  input  logic [LEN_W-1:0] cfg_low_m1,
  input  logic [PSC_W-1:0] cfg_pg_div_log2,
  input  logic             cfg_ss_en,
  input  logic [DEV_W-1:0] cfg_ss_dev,
  input  logic             cfg_ss_div2,
  output logic             xfer_phase,
  output logic             cycle_done,
  output logic             cfg_err
);
  logic             illegal;
  logic             pg_tick, ss_tick;
  logic             pg_restart, ss_restart, idle;
  logic [DEV_W-1:0] stretch_amt;

  // divider 1 forbids a 2-tick low phase, divider 2 forbids a 1-tick one
  assign illegal = ((cfg_pg_div_log2 == PSC_W'(0)) && (cfg_low_m1 == LEN_W'(1))) ||
                   ((cfg_pg_div_log2 == PSC_W'(1)) && (cfg_low_m1 == LEN_W'(0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= illegal;
  end

  xpg_prescaler #(.PSC_W(PSC_W)) u_pg_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (pg_restart),
    .div_log2 (cfg_pg_div_log2),
    .tick     (pg_tick)
  );

  xpg_prescaler #(.PSC_W(1)) u_ss_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ss_restart),
    .div_log2 (cfg_ss_div2),
    .tick     (ss_tick)
  );

  xpg_sweep #(.DEV_W(DEV_W)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_ss_en),
    .clear   (idle),
    .advance (cycle_done),
    .dev     (cfg_ss_dev),
    .amt     (stretch_amt)
  );

  xpg_seq #(.LEN_W(LEN_W), .DEV_W(DEV_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .illegal     (illegal),
    .high_m1     (cfg_high_m1),
    .low_m1      (cfg_low_m1),
    .pg_tick     (pg_tick),
    .ss_tick     (ss_tick),
    .stretch_amt (stretch_amt),
    .pg_restart  (pg_restart),
    .ss_restart  (ss_restart),
    .idle        (idle),
    .xfer_phase  (xfer_phase),
    .cycle_done  (cycle_done)
  );

  // R2: the strobe only falls in the low phase
  a_r2_strobe_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> !xfer_phase);

  // R8: run low at the end of a cycle stops the generator
  a_r8_stop_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && !run) |=> (!xfer_phase && !cycle_done));

  // R4: the error flag follows an illegal combination one clock later
  a_r4_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> cfg_err);
endmodule

// File: tb/xfer_pulse_gen_bench.sv
`timescale 1ns/1ps
module xfer_pulse_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [3:0] cfg_high_m1 = 4'd0;
  logic [3:0] cfg_low_m1 = 4'd0;
  logic [2:0] cfg_pg_div_log2 = 3'd0;
  logic       cfg_ss_en = 1'b0;
  logic [6:0] cfg_ss_dev = 7'd0;
  logic       cfg_ss_div2 = 1'b0;
  logic       xfer_phase, cycle_done, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xfer_pulse_gen u_xfer_pulse_gen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_high_m1(cfg_high_m1), .cfg_low_m1(cfg_low_m1),
    .cfg_pg_div_log2(cfg_pg_div_log2), .cfg_ss_en(cfg_ss_en),
    .cfg_ss_dev(cfg_ss_dev), .cfg_ss_div2(cfg_ss_div2),
    .xfer_phase(xfer_phase), .cycle_done(cycle_done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tri_amt(input int k, input int dev);
    int m;
    if (dev == 0) return 0;
    m = k % (2 * dev);
    return (m <= dev) ? m : 2 * dev - m;
  endfunction

  // Runs ncyc cycles from a stopped state; called at a negedge.
  task automatic run_cycles(input int ncyc, input bit stop_mid, input string tag);
    int d, s, p, hi, lo, guard;
    d = 1 << cfg_pg_div_log2;
    p = cfg_ss_div2 ? 2 : 1;
    run = 1'b1;
    @(negedge clk);
    chk(xfer_phase == 1'b1, "R10 start latency", int'(xfer_phase), 1);
    for (int c = 0; c < ncyc; c++) begin
      hi = 0; lo = 0; guard = 0;
      s = cfg_ss_en ? tri_amt(c, int'(cfg_ss_dev)) : 0;
      forever begin
        if (xfer_phase) hi++; else lo++;
        if (stop_mid && c == ncyc - 1 && hi == 1) run = 1'b0;
        if (cycle_done) break;
        guard++;
        if (guard > 60000) break;
        @(negedge clk);
      end
      if (c == ncyc - 1) run = 1'b0;
      chk(hi == (int'(cfg_high_m1) + 1) * d + s * p,
          {tag, " R1/R6 high length"}, hi, (int'(cfg_high_m1) + 1) * d + s * p);
      chk(lo == (int'(cfg_low_m1) + 1) * d,
          {tag, " R2/R3 low length"}, lo, (int'(cfg_low_m1) + 1) * d);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      chk(!xfer_phase && !cycle_done, {tag, " R8 stopped"}, int'(xfer_phase), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!xfer_phase, "R9 xfer_phase", int'(xfer_phase), 0);
    chk(!cycle_done, "R9 cycle_done", int'(cycle_done), 0);
    chk(!cfg_err, "R9 cfg_err", int'(cfg_err), 0);

    // R1 R2 sweep of all phase lengths at divider 1
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        if (l != 1) begin
          cfg_high_m1 = 4'(h); cfg_low_m1 = 4'(l);
          run_cycles(2, 1'b0, "R1 sweep");
        end
      end
    end

    // R3 every divider
    cfg_high_m1 = 4'd1; cfg_low_m1 = 4'd2;
    for (int dv = 0; dv < 8; dv++) begin
      cfg_pg_div_log2 = 3'(dv);
      run_cycles(2, 1'b0, "R3 divider");
    end

    // R6 R7 spread spectrum triangles
    cfg_pg_div_log2 = 3'd0; cfg_high_m1 = 4'd0; cfg_low_m1 = 4'd0;
    cfg_ss_en = 1'b1;
    for (int sd = 0; sd < 2; sd++) begin
      for (int dev = 0; dev < 5; dev++) begin
        cfg_ss_div2 = sd[0]; cfg_ss_dev = 7'(dev);
        run_cycles(4 * dev + 3, 1'b0, sd ? "R7 div2" : "R6 tri");
      end
    end
    cfg_pg_div_log2 = 3'd2; cfg_ss_dev = 7'd127; cfg_ss_div2 = 1'b1;
    run_cycles(3, 1'b0, "R6 max dev");
    cfg_ss_en = 1'b0;

    // R8 run dropped inside the high phase
    cfg_pg_div_log2 = 3'd2; cfg_high_m1 = 4'd3; cfg_low_m1 = 4'd3;
    run_cycles(3, 1'b1, "R8 mid stop");

    // R4 R5 illegal combinations
    for (int e = 0; e < 2; e++) begin
      cfg_pg_div_log2 = 3'(e); cfg_low_m1 = (e == 0) ? 4'd1 : 4'd0;
      run = 1'b1;
      @(negedge clk);
      chk(cfg_err, "R4 flag set", int'(cfg_err), 1);
      for (int i = 0; i < 20; i++) begin
        chk(!xfer_phase && !cycle_done, "R5 held stopped", int'(xfer_phase), 0);
        @(negedge clk);
      end
      run = 1'b0;
      cfg_low_m1 = (e == 0) ? 4'd0 : 4'd1;
      @(negedge clk);
      chk(!cfg_err, "R4 flag clear", int'(cfg_err), 0);
      run_cycles(2, 1'b0, "R5 restart");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule